// File: doc/BRIEF.md
# SD Host Single-Address DMA Engine

This block moves the data phase of an SD data command between the card-side data path and system memory, one word at a time, using a single running system address. Software sets the starting address, the block length, the number of blocks and the transfer direction through a small register file. The command sequencer then pulses `data_start`. The engine alternates between the data path and a request/acknowledge memory port until every block is moved, and then raises a transfer-complete status bit.

Each time the next address lands on a multiple of a programmable power-of-two window, the engine raises a DMA status bit and halts. Software resumes the transfer by writing the system address register, even with the value it reads back, because that register always holds the next address the engine will access. Status bits are cleared by writing ones. A bit is recorded only when its enable bit is set, and `irq` is high while any recorded bit is set.

Register word offsets on `reg_addr`: 0 system address, 1 block configuration, 2 block count, 3 transfer mode, 4 host control, 5 status, 6 status enable. Offset 7 reads zero.

Top module: `sdma_engine_top`

## Requirements
- R1: After reset every register reads zero, `irq` is low and no memory request or data-path handshake is active.
- R2: Block configuration holds the block length in bytes in bits [11:0] and the window code in bits [14:12]. Transfer mode keeps bit 0 (DMA enable), bit 1 (count enable), bit 2 (auto stop enable), bit 4 (direction, 1 = card to memory) and bit 5 (multi-block). Its bit 3 reads zero. Host control keeps only the DMA-select field in bits [4:3].
- R3: A `data_start` pulse starts a transfer only when mode bit 0 is set and the DMA-select field is 00. Otherwise nothing is requested and the address does not change.
- R4: With mode bit 4 set, words taken from the data path are written to consecutive memory addresses that step by 4 bytes from the system address. The system address reads back the next address to be accessed.
- R5: With mode bit 4 clear, words read from consecutive memory addresses are presented on the data path in address order.
- R6: With mode bits 5 and 1 set, the block count decrements once per finished block, and the transfer ends when it reaches zero.
- R7: With mode bit 5 clear, exactly one block is moved. With mode bit 1 clear, the block count register keeps its value.
- R8: When the next address is a multiple of 4 KiB shifted left by the window code, and the transfer is not finished, status bit 3 is set and no further memory request is issued.
- R9: A write to the system address register during a halt resumes the transfer from the written address.
- R10: When the final word leaves the address on a window multiple, transfer complete (status bit 1) is set and status bit 3 is not.
- R11: Status bits 0, 1 and 3 are cleared by writing 1 and unchanged by writing 0. A hardware set in the same cycle as a clear leaves the bit set.
- R12: A status bit is recorded only when the same bit of the status-enable register is set, and `irq` equals the OR of the status bits.
- R13: A `cmd_done` pulse sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| cmd_done | input | 1 | Command-complete pulse from the command sequencer |
| data_start | input | 1 | Data command issued; starts the data phase |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| dp_rx_valid | input | 1 | Word available from the card side |
| dp_rx_data | input | 32 | Word from the card side |
| dp_rx_ready | output | 1 | Engine accepts a card-side word |
| dp_tx_valid | output | 1 | Word offered to the card side |
| dp_tx_data | output | 32 | Word to the card side |
| dp_tx_ready | input | 1 | Card side accepts the word |
| irq | output | 1 | OR of the recorded status bits |

## Verification
The collision that matters is a software write-one-to-clear of transfer complete landing in the same cycle as the engine setting that bit on the acknowledge of the final word. The bench leaves the bit set from a prior transfer and runs a one-word transfer. It watches for the memory acknowledge at a falling edge and issues the status write so that both are sampled at the same rising edge. The bit must still read as set, and a later clear must remove it. A second pairing is the halt at a window edge, where the block-count decrement and the DMA status bit arrive together. The bench checks both the count and the address at the halt.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int REG_W = 32;
    localparam int OFS_W = 3;

    localparam logic [OFS_W-1:0] OFS_ADDR  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_BCFG  = 3'd1;
    localparam logic [OFS_W-1:0] OFS_BCNT  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_MODE  = 3'd3;
    localparam logic [OFS_W-1:0] OFS_HCTL  = 3'd4;
    localparam logic [OFS_W-1:0] OFS_STAT  = 3'd5;
    localparam logic [OFS_W-1:0] OFS_STEN  = 3'd6;

    localparam int MB_DMA   = 0;
    localparam int MB_CNT   = 1;
    localparam int MB_ASTOP = 2;
    localparam int MB_DIR   = 4;
    localparam int MB_MULTI = 5;
    localparam logic [5:0] MODE_MASK = 6'b110111;

    localparam int ST_CMD  = 0;
    localparam int ST_XFER = 1;
    localparam int ST_DMA  = 3;
    localparam logic [5:0] STAT_MASK = 6'b001011;

    localparam int SEL_LO = 3;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DP    = 2'd1,
        S_MEM   = 2'd2,
        S_PAUSE = 2'd3
    } eng_state_t;

endpackage

// File: rtl/sdma_boundary.sv
module sdma_boundary #(
    parameter int BND_BASE = 12,
    parameter int CODE_W   = 3,
    localparam int NCODES  = 1 << CODE_W,
    localparam int LOW_W   = BND_BASE + NCODES - 1
) (
    input  logic [LOW_W-1:0]  addr_low,
    input  logic [CODE_W-1:0] code,
    output logic              hit
);

    logic [NCODES-1:0] hits;

    for (genvar c = 0; c < NCODES; c++) begin : g_code
        assign hits[c] = (addr_low[BND_BASE+c-1:0] == '0);
    end

    assign hit = hits[code];

endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
    import sdma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int SIZE_W   = 12,
    parameter int CNT_W    = 16,
    parameter int CODE_W   = 3,
    localparam int WB      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              cmd_done,
    input  logic              addr_inc,
    input  logic              cnt_dec,
    input  logic              set_done,
    input  logic              set_dma_int,
    output logic [ADDR_W-1:0] sysaddr,
    output logic [SIZE_W-1:0] blk_size,
    output logic [CODE_W-1:0] bnd_code,
    output logic [CNT_W-1:0]  blk_cnt,
    output logic              dma_en,
    output logic              cnt_en,
    output logic              dir_rd,
    output logic              multi,
    output logic [1:0]        dma_sel,
    output logic              resume,
    output logic              irq
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  cnt;
        logic [5:0]        mode;
        logic [1:0]        sel;
        logic [5:0]        stat;
        logic [5:0]        sten;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_addr, wr_cnt, wr_stat;
    logic [5:0] hw_set;

    assign wr_addr = reg_we && (reg_addr == OFS_ADDR);
    assign wr_cnt  = reg_we && (reg_addr == OFS_BCNT);
    assign wr_stat = reg_we && (reg_addr == OFS_STAT);

    always_comb begin
        r_d = r_q;
        hw_set = '0;
        hw_set[ST_CMD]  = cmd_done;
        hw_set[ST_XFER] = set_done;
        hw_set[ST_DMA]  = set_dma_int;

        if (wr_addr)       r_d.addr = reg_wdata[ADDR_W-1:0];
        else if (addr_inc) r_d.addr = r_q.addr + ADDR_W'(WB);

        if (wr_cnt)       r_d.cnt = reg_wdata[CNT_W-1:0];
        else if (cnt_dec) r_d.cnt = r_q.cnt - CNT_W'(1);

        if (reg_we && reg_addr == OFS_BCFG) begin
            r_d.size = reg_wdata[SIZE_W-1:0];
            r_d.code = reg_wdata[SIZE_W +: CODE_W];
        end
        if (reg_we && reg_addr == OFS_MODE) r_d.mode = reg_wdata[5:0] & MODE_MASK;
        if (reg_we && reg_addr == OFS_HCTL) r_d.sel  = reg_wdata[SEL_LO +: 2];
        if (reg_we && reg_addr == OFS_STEN) r_d.sten = reg_wdata[5:0];

        r_d.stat = r_q.stat & ~(wr_stat ? reg_wdata[5:0] : 6'b0);
        r_d.stat = (r_d.stat | (hw_set & r_q.sten)) & STAT_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_addr)
            OFS_ADDR: reg_rdata = REG_W'(r_q.addr);
            OFS_BCFG: reg_rdata = REG_W'({r_q.code, r_q.size});
            OFS_BCNT: reg_rdata = REG_W'(r_q.cnt);
            OFS_MODE: reg_rdata = REG_W'(r_q.mode);
            OFS_HCTL: reg_rdata = REG_W'({r_q.sel, 3'b000});
            OFS_STAT: reg_rdata = REG_W'(r_q.stat);
            OFS_STEN: reg_rdata = REG_W'(r_q.sten);
            default:  reg_rdata = '0;
        endcase
    end

    assign sysaddr  = r_q.addr;
    assign blk_size = r_q.size;
    assign bnd_code = r_q.code;
    assign blk_cnt  = r_q.cnt;
    assign dma_en   = r_q.mode[MB_DMA];
    assign cnt_en   = r_q.mode[MB_CNT];
    assign dir_rd   = r_q.mode[MB_DIR];
    assign multi    = r_q.mode[MB_MULTI];
    assign dma_sel  = r_q.sel;
    assign resume   = wr_addr;
    assign irq      = |r_q.stat;

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_inc && !wr_addr |=> r_q.addr == $past(r_q.addr) + ADDR_W'(WB));

    assert_cnt_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_dec && !wr_cnt |=> r_q.cnt == $past(r_q.cnt) - CNT_W'(1));

    assert_w1c_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && reg_wdata[ST_XFER] && !set_done |=> !r_q.stat[ST_XFER]);

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_done && r_q.sten[ST_XFER] |=> r_q.stat[ST_XFER]);

    assert_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.sten[ST_DMA] && !r_q.stat[ST_DMA] |=> !r_q.stat[ST_DMA]);

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
    import sdma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int SIZE_W   = 12,
    parameter int CNT_W    = 16,
    parameter int CODE_W   = 3,
    parameter int BND_BASE = 12,
    localparam int WB      = DATA_W / 8,
    localparam int LOW_W   = BND_BASE + (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dma_en,
    input  logic [1:0]        dma_sel,
    input  logic              cnt_en,
    input  logic              dir_rd,
    input  logic              multi,
    input  logic [SIZE_W-1:0] blk_size,
    input  logic [CNT_W-1:0]  blk_cnt,
    input  logic [CODE_W-1:0] bnd_code,
    input  logic [ADDR_W-1:0] sysaddr,
    input  logic              resume,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              dp_rx_valid,
    input  logic [DATA_W-1:0] dp_rx_data,
    output logic              dp_rx_ready,
    output logic              dp_tx_valid,
    output logic [DATA_W-1:0] dp_tx_data,
    input  logic              dp_tx_ready,
    output logic              addr_inc,
    output logic              cnt_dec,
    output logic              set_done,
    output logic              set_dma_int
);

    typedef struct packed {
        eng_state_t        state;
        logic [DATA_W-1:0] word;
        logic [SIZE_W:0]   bytes;
    } eng_t;

    eng_t e_d, e_q;
    eng_state_t first_st;
    logic [LOW_W-1:0] next_low;
    logic at_bnd, word_done, blk_end, last_blk;

    assign first_st = dir_rd ? S_DP : S_MEM;
    assign next_low = sysaddr[LOW_W-1:0] + LOW_W'(WB);

    sdma_boundary #(
        .BND_BASE (BND_BASE),
        .CODE_W   (CODE_W)
    ) u_bnd (
        .addr_low (next_low),
        .code     (bnd_code),
        .hit      (at_bnd)
    );

    assign blk_end  = (e_q.bytes + (SIZE_W+1)'(WB)) >= {1'b0, blk_size};
    assign last_blk = !multi || (cnt_en && blk_cnt == CNT_W'(1));

    always_comb begin
        e_d         = e_q;
        mem_req     = 1'b0;
        dp_rx_ready = 1'b0;
        dp_tx_valid = 1'b0;
        word_done   = 1'b0;
        addr_inc    = 1'b0;
        cnt_dec     = 1'b0;
        set_done    = 1'b0;
        set_dma_int = 1'b0;

        case (e_q.state)
            S_IDLE: begin
                if (start && dma_en && dma_sel == 2'b00) begin
                    e_d.bytes = '0;
                    e_d.state = first_st;
                end
            end
            S_DP: begin
                if (dir_rd) begin
                    dp_rx_ready = 1'b1;
                    if (dp_rx_valid) begin
                        e_d.word  = dp_rx_data;
                        e_d.state = S_MEM;
                    end
                end else begin
                    dp_tx_valid = 1'b1;
                    word_done   = dp_tx_ready;
                end
            end
            S_MEM: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    if (dir_rd) begin
                        word_done = 1'b1;
                    end else begin
                        e_d.word  = mem_rdata;
                        e_d.state = S_DP;
                    end
                end
            end
            S_PAUSE: begin
                if (resume) e_d.state = first_st;
            end
            default: e_d.state = S_IDLE;
        endcase

        if (word_done) begin
            addr_inc  = 1'b1;
            e_d.bytes = blk_end ? '0 : e_q.bytes + (SIZE_W+1)'(WB);
            cnt_dec   = blk_end && cnt_en;
            if (blk_end && last_blk) begin
                set_done  = 1'b1;
                e_d.state = S_IDLE;
            end else if (at_bnd) begin
                set_dma_int = 1'b1;
                e_d.state   = S_PAUSE;
            end else begin
                e_d.state = first_st;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{state: S_IDLE, word: '0, bytes: '0};
        else        e_q <= e_d;
    end

    assign mem_we     = dir_rd;
    assign mem_addr   = sysaddr;
    assign mem_wdata  = e_q.word;
    assign dp_tx_data = e_q.word;

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !resume |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_pause_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_dma_int |=> !mem_req);

    assert_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.state == S_IDLE) && (dma_sel != 2'b00) |=> !mem_req && !dp_rx_ready && !dp_tx_valid);

endmodule

// File: rtl/sdma_engine_top.sv
module sdma_engine_top
    import sdma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int SIZE_W   = 12,
    parameter int CNT_W    = 16,
    parameter int CODE_W   = 3,
    parameter int BND_BASE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [OFS_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              cmd_done,
    input  logic              data_start,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              dp_rx_valid,
    input  logic [DATA_W-1:0] dp_rx_data,
    output logic              dp_rx_ready,
    output logic              dp_tx_valid,
    output logic [DATA_W-1:0] dp_tx_data,
    input  logic              dp_tx_ready,
    output logic              irq
);

    logic [ADDR_W-1:0] sysaddr;
    logic [SIZE_W-1:0] blk_size;
    logic [CODE_W-1:0] bnd_code;
    logic [CNT_W-1:0]  blk_cnt;
    logic [1:0]        dma_sel;
    logic dma_en, cnt_en, dir_rd, multi, resume;
    logic addr_inc, cnt_dec, set_done, set_dma_int;

    sdma_regs #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SIZE_W (SIZE_W),
        .CNT_W  (CNT_W),  .CODE_W (CODE_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .cmd_done    (cmd_done),
        .addr_inc    (addr_inc),
        .cnt_dec     (cnt_dec),
        .set_done    (set_done),
        .set_dma_int (set_dma_int),
        .sysaddr     (sysaddr),
        .blk_size    (blk_size),
        .bnd_code    (bnd_code),
        .blk_cnt     (blk_cnt),
        .dma_en      (dma_en),
        .cnt_en      (cnt_en),
        .dir_rd      (dir_rd),
        .multi       (multi),
        .dma_sel     (dma_sel),
        .resume      (resume),
        .irq         (irq)
    );

    sdma_engine #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SIZE_W (SIZE_W),
        .CNT_W  (CNT_W),  .CODE_W (CODE_W), .BND_BASE (BND_BASE)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (data_start),
        .dma_en      (dma_en),
        .dma_sel     (dma_sel),
        .cnt_en      (cnt_en),
        .dir_rd      (dir_rd),
        .multi       (multi),
        .blk_size    (blk_size),
        .blk_cnt     (blk_cnt),
        .bnd_code    (bnd_code),
        .sysaddr     (sysaddr),
        .resume      (resume),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ack     (mem_ack),
        .dp_rx_valid (dp_rx_valid),
        .dp_rx_data  (dp_rx_data),
        .dp_rx_ready (dp_rx_ready),
        .dp_tx_valid (dp_tx_valid),
        .dp_tx_data  (dp_tx_data),
        .dp_tx_ready (dp_tx_ready),
        .addr_inc    (addr_inc),
        .cnt_dec     (cnt_dec),
        .set_done    (set_done),
        .set_dma_int (set_dma_int)
    );

endmodule

// File: tb/test_sdma_engine_top.sv
module test_sdma_engine_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam logic [31:0] RX_BASE = 32'h5500_0000;

    localparam logic [2:0] A_ADDR = 3'd0, A_BCFG = 3'd1, A_BCNT = 3'd2,
                           A_MODE = 3'd3, A_HCTL = 3'd4, A_STAT = 3'd5, A_STEN = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic cmd_done = 1'b0, data_start = 1'b0;
    logic mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic mem_ack = 1'b0;
    logic dp_rx_valid = 1'b1;
    logic [31:0] dp_rx_data;
    logic dp_rx_ready, dp_tx_valid;
    logic [31:0] dp_tx_data;
    logic dp_tx_ready = 1'b1;
    logic irq;

    logic [31:0] mem [0:1023];
    logic [31:0] tx_log [0:63];
    int rx_cnt = 0;
    int tx_n = 0;
    int n_total = 0;
    int n_fail = 0;

    assign dp_rx_data = RX_BASE + 32'(rx_cnt);

    always #(CLK_PERIOD/2) clk = ~clk;

    sdma_engine_top i_sdma_engine_top (
        .clk (clk), .rst_n (rst_n),
        .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .cmd_done (cmd_done), .data_start (data_start),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata), .mem_ack (mem_ack),
        .dp_rx_valid (dp_rx_valid), .dp_rx_data (dp_rx_data), .dp_rx_ready (dp_rx_ready),
        .dp_tx_valid (dp_tx_valid), .dp_tx_data (dp_tx_data), .dp_tx_ready (dp_tx_ready),
        .irq (irq)
    );

    initial begin
        forever begin
            @(posedge clk);
            if (mem_req && mem_ack && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[11:2]];
            mem_ack   <= mem_req && !mem_ack;
            if (dp_rx_valid && dp_rx_ready) rx_cnt <= rx_cnt + 1;
            if (dp_tx_valid && dp_tx_ready) begin
                tx_log[tx_n[5:0]] <= dp_tx_data;
                tx_n <= tx_n + 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_start();
        data_start = 1'b1;
        @(negedge clk);
        data_start = 1'b0;
    endtask

    task automatic setup(input logic [31:0] addr, input logic [31:0] cfg,
                         input logic [31:0] cnt, input logic [31:0] mode);
        reg_wr(A_ADDR, addr);
        reg_wr(A_BCFG, cfg);
        reg_wr(A_BCNT, cnt);
        reg_wr(A_MODE, mode);
    endtask

    task automatic wait_bits(input logic [31:0] mask, output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            reg_rd(A_STAT, v);
            if ((v & mask) != 0) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic idle_watch(input int cycles, output int reqs);
        reqs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (mem_req || dp_rx_ready || dp_tx_valid) reqs++;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog actual=%0d cycles expected=fewer", WATCHDOG);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        logic [31:0] v;
        bit ok;
        int base, reqs;

        for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
        repeat (3) @(negedge clk);

        // R1: reset state
        check("R1 mem_req", {31'b0, mem_req}, 32'd0);
        check("R1 irq", {31'b0, irq}, 32'd0);
        for (int a = 0; a < 8; a++) begin
            reg_rd(3'(a), v);
            check("R1 reg reset", v, 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: field layout readback
        reg_wr(A_BCFG, 32'hFFFF_7ABC);
        reg_rd(A_BCFG, v); check("R2 blkcfg", v, 32'h0000_7ABC);
        reg_wr(A_MODE, 32'hFF);
        reg_rd(A_MODE, v); check("R2 mode bit3 zero", v, 32'h37);
        reg_wr(A_HCTL, 32'hFF);
        reg_rd(A_HCTL, v); check("R2 hostctl sel", v, 32'h18);
        reg_wr(A_HCTL, 32'h0);
        reg_wr(A_STEN, 32'h0B);

        // R3: non-simple DMA select ignores start
        setup(32'h500, 32'h8, 32'd2, 32'h11);
        reg_wr(A_HCTL, 32'h10);
        pulse_start();
        idle_watch(30, reqs);
        check("R3 sel!=00 no activity", 32'(reqs), 32'd0);
        reg_rd(A_ADDR, v); check("R3 sel!=00 addr", v, 32'h500);
        reg_wr(A_HCTL, 32'h0);
        // R3: DMA enable clear ignores start
        reg_wr(A_MODE, 32'h10);
        pulse_start();
        idle_watch(30, reqs);
        check("R3 dma_en=0 no activity", 32'(reqs), 32'd0);
        reg_rd(A_STAT, v); check("R3 status untouched", v, 32'd0);

        // R4 R7: single block card->memory, count disabled
        base = rx_cnt;
        setup(32'h100, 32'd16, 32'd5, 32'h11);
        pulse_start();
        wait_bits(32'h2, ok);
        check("R7 single done", {31'b0, ok}, 32'd1);
        for (int i = 0; i < 4; i++)
            check("R4 rd word", mem[64 + i], RX_BASE + 32'(base + i));
        check("R7 no extra word", mem[68], 32'hDEAD_0000 + 32'd68);
        reg_rd(A_BCNT, v); check("R7 count kept", v, 32'd5);
        reg_rd(A_ADDR, v); check("R4 next addr", v, 32'h110);
        reg_rd(A_STAT, v); check("R12 status value", v, 32'h2);
        check("R12 irq", {31'b0, irq}, 32'd1);

        // R11: write 0 keeps, write 1 clears
        reg_wr(A_STAT, 32'h0);
        reg_rd(A_STAT, v); check("R11 w0 keeps", v, 32'h2);
        reg_wr(A_STAT, 32'h2);
        reg_rd(A_STAT, v); check("R11 w1 clears", v, 32'h0);
        check("R12 irq low", {31'b0, irq}, 32'd0);

        // R6: multi block with count
        base = rx_cnt;
        setup(32'h200, 32'd8, 32'd3, 32'h33);
        pulse_start();
        wait_bits(32'h2, ok);
        check("R6 multi done", {31'b0, ok}, 32'd1);
        for (int i = 0; i < 6; i++)
            check("R6 rd word", mem[128 + i], RX_BASE + 32'(base + i));
        check("R6 stops at zero", mem[134], 32'hDEAD_0000 + 32'd134);
        reg_rd(A_BCNT, v); check("R6 count zero", v, 32'd0);
        reg_wr(A_STAT, 32'h3F);

        // R5: memory->card
        for (int i = 0; i < 4; i++) mem[192 + i] = 32'hA000 + 32'(i);
        base = tx_n;
        setup(32'h300, 32'd8, 32'd2, 32'h23);
        pulse_start();
        wait_bits(32'h2, ok);
        check("R5 wr done", {31'b0, ok}, 32'd1);
        @(negedge clk);
        check("R5 tx count", 32'(tx_n - base), 32'd4);
        for (int i = 0; i < 4; i++)
            check("R5 tx word", tx_log[6'(base + i)], 32'hA000 + 32'(i));
        reg_wr(A_STAT, 32'h3F);

        // R8 R9: halt at 4 KiB and resume on address write
        base = rx_cnt;
        setup(32'hFF8, 32'h0000_0008, 32'd2, 32'h33);
        pulse_start();
        wait_bits(32'h8, ok);
        check("R8 dma int raised", {31'b0, ok}, 32'd1);
        reg_rd(A_STAT, v); check("R8 not complete", v & 32'h2, 32'd0);
        reg_rd(A_ADDR, v); check("R8 halt addr", v, 32'h1000);
        reg_rd(A_BCNT, v); check("R8 count at halt", v, 32'd1);
        idle_watch(20, reqs);
        check("R8 halted quiet", 32'(reqs), 32'd0);
        reg_wr(A_STAT, 32'h8);
        reg_rd(A_STAT, v); check("R11 dma int clear", v, 32'h0);
        reg_wr(A_ADDR, 32'h1000);
        wait_bits(32'h2, ok);
        check("R9 resumed done", {31'b0, ok}, 32'd1);
        check("R9 word0", mem[1022], RX_BASE + 32'(base));
        check("R9 word1", mem[1023], RX_BASE + 32'(base + 1));
        check("R9 word2", mem[0], RX_BASE + 32'(base + 2));
        check("R9 word3", mem[1], RX_BASE + 32'(base + 3));
        reg_rd(A_ADDR, v); check("R9 final addr", v, 32'h1008);
        reg_wr(A_STAT, 32'h3F);

        // R8: code 1 selects 8 KiB, so crossing 0x1000 does not halt
        setup(32'hFF8, 32'h0000_1008, 32'd2, 32'h33);
        pulse_start();
        wait_bits(32'h2, ok);
        check("R8 code1 done", {31'b0, ok}, 32'd1);
        reg_rd(A_STAT, v); check("R8 code1 no halt", v, 32'h2);
        reg_rd(A_ADDR, v); check("R8 code1 addr", v, 32'h1008);
        reg_wr(A_STAT, 32'h3F);

        // R10: last word ends on window
        setup(32'h1FF8, 32'h0000_0008, 32'd0, 32'h11);
        pulse_start();
        wait_bits(32'h2, ok);
        check("R10 done", {31'b0, ok}, 32'd1);
        repeat (3) @(negedge clk);
        reg_rd(A_STAT, v); check("R10 no dma int", v, 32'h2);
        reg_rd(A_ADDR, v); check("R10 addr", v, 32'h2000);

        // R11: hardware set and software clear in the same cycle
        setup(32'h3C0, 32'd4, 32'd0, 32'h11);
        pulse_start();
        for (int i = 0; i < 50; i++) begin
            if (mem_ack) break;
            @(negedge clk);
        end
        reg_wr(A_STAT, 32'h2);
        reg_rd(A_STAT, v); check("R11 set wins", v & 32'h2, 32'h2);
        reg_wr(A_STAT, 32'h2);
        reg_rd(A_STAT, v); check("R11 later clear", v, 32'h0);

        // R12: disabled status bit is not recorded
        reg_wr(A_STEN, 32'h09);
        setup(32'h380, 32'd4, 32'd0, 32'h11);
        pulse_start();
        repeat (40) @(negedge clk);
        reg_rd(A_STAT, v); check("R12 gated", v, 32'h0);
        check("R12 irq gated", {31'b0, irq}, 32'd0);
        reg_rd(A_ADDR, v); check("R12 transfer ran", v, 32'h384);

        // R13: command complete
        reg_wr(A_STEN, 32'h0B);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        reg_rd(A_STAT, v); check("R13 cmd bit", v, 32'h1);
        check("R13 irq", {31'b0, irq}, 32'd1);
        reg_wr(A_STAT, 32'h1);
        reg_rd(A_STAT, v); check("R13 cleared", v, 32'h0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule